// File: doc/BRIEF.md
# Recursive Quadrant Multiplier (16 x 16 unsigned)

This block multiplies two unsigned 16-bit operands and returns the full 32-bit product with no clock, reset or storage. The product is not formed from a flat partial-product array or a `*` operator. It is built level by level from a 2x2 cell made of AND gates and two half adders. At each level, four half-width products are merged by three adders arranged in two addition stages.

Each level is its own module (2x2, 4x4, 8x8 and the 16x16 top), so any level can be used or checked on its own. All levels share one parameterised merge stage. At a W-bit level, the four sub-products are W bits wide. The merge uses one W-bit adder and two 3W/2-bit adders. The low W/2 bits of the low-by-low sub-product pass straight to the result.

Top module: `qmul16`

## Requirements
- R1: `prod` equals the unsigned product of `op_a` and `op_b` for every pair of 16-bit operands.
- R2: The 2x2 cell gives the exact product of two 2-bit values. Bit 0 is the AND of both low bits. Its largest output is 9, and it gives 9 only when both inputs are 3.
- R3: At every level, a zero on either operand gives an all-zero product.
- R4: At every level, when one operand equals 1 the product equals the other operand, zero-extended.
- R5: At every level, bit 0 of the product equals the AND of bit 0 of the two operands.
- R6: 16'hFFFF times 16'hFFFF gives 32'hFFFE0001.
- R7: The 4x4 and 8x8 levels, used standalone, each return the exact unsigned product of their operands.
- R8: Inside each merge stage no adder wraps. The first sum is never smaller than the high-by-low sub-product, and the final sum is never smaller than the upper partial sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| prod | output | 32 | Unsigned 32-bit product |

## Verification
On every input change, the assertions check the following:
- the top-level product is exact;
- zero and unit operands give the expected result at each level;
- bit 0 of each product is correct;
- the 2x2 cell never exceeds 9;
- no merge adder wraps.

Only the bench's scenarios show that the intermediate levels are exact on their own. The 2x2 and 4x4 levels are swept exhaustively and the 8x8 level with random pairs. The bench scenarios also cover the named corner products, such as all-ones squared and products with a single high bit set.

// File: rtl/qmul16.sv
module qmul2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic t_lo, t_x, t_hi, c1;
  assign t_x  = a[1] & b[0];
  assign t_lo = a[0] & b[1];
  assign t_hi = a[1] & b[1];
  assign p[0] = a[0] & b[0];
  assign p[1] = t_x ^ t_lo;
  assign c1   = t_x & t_lo;
  assign p[2] = t_hi ^ c1;
  assign p[3] = t_hi & c1;

  always_comb begin
    p_cell_max_r2: assert (p <= 4'd9);
    p_cell_nine_r2: assert (p != 4'd9 || (a == 2'd3 && b == 2'd3));
  end
endmodule

module qmul_merge #(
  parameter int W = 4
) (
  input  logic [W-1:0]   ll,
  input  logic [W-1:0]   hl,
  input  logic [W-1:0]   lh,
  input  logic [W-1:0]   hh,
  output logic [2*W-1:0] prod
);
  localparam int H = W / 2;
  logic [W-1:0]   s_mid;
  logic [3*H-1:0] s_hi, s_fin;

  assign s_mid = hl + {{H{1'b0}}, ll[W-1:H]};
  assign s_hi  = {hh, {H{1'b0}}} + {{H{1'b0}}, lh};
  assign s_fin = {{H{1'b0}}, s_mid} + s_hi;
  assign prod  = {s_fin, ll[H-1:0]};

  always_comb begin
    p_no_overflow_r8: assert (s_mid >= hl);
    p_fin_no_wrap_r8: assert (s_fin >= s_hi);
  end
endmodule

module qmul4 (
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [7:0] p
);
  logic [3:0] pp [4];
  for (genvar k = 0; k < 4; k++) begin : g_q
    qmul2 u_c (.a(a[(k%2)*2 +: 2]), .b(b[(k/2)*2 +: 2]), .p(pp[k]));
  end
  qmul_merge #(.W(4)) u_m (.ll(pp[0]), .hl(pp[1]), .lh(pp[2]), .hh(pp[3]), .prod(p));

  always_comb begin
    p_zero_r3: assert ((a != 0 && b != 0) || p == 0);
    p_unit_r4: assert (a != 4'd1 || p == {4'd0, b});
    p_lsb_r5:  assert (p[0] == (a[0] & b[0]));
  end
endmodule

module qmul8 (
  input  logic [7:0]  a,
  input  logic [7:0]  b,
  output logic [15:0] p
);
  logic [7:0] pp [4];
  for (genvar k = 0; k < 4; k++) begin : g_q
    qmul4 u_c (.a(a[(k%2)*4 +: 4]), .b(b[(k/2)*4 +: 4]), .p(pp[k]));
  end
  qmul_merge #(.W(8)) u_m (.ll(pp[0]), .hl(pp[1]), .lh(pp[2]), .hh(pp[3]), .prod(p));

  always_comb begin
    p_zero_r3: assert ((a != 0 && b != 0) || p == 0);
    p_unit_r4: assert (b != 8'd1 || p == {8'd0, a});
    p_lsb_r5:  assert (p[0] == (a[0] & b[0]));
  end
endmodule

module qmul16 (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  output logic [31:0] prod
);
  logic [15:0] pp [4];
  for (genvar k = 0; k < 4; k++) begin : g_q
    qmul8 u_c (.a(op_a[(k%2)*8 +: 8]), .b(op_b[(k/2)*8 +: 8]), .p(pp[k]));
  end
  qmul_merge #(.W(16)) u_m (.ll(pp[0]), .hl(pp[1]), .lh(pp[2]), .hh(pp[3]), .prod(prod));

  always_comb begin
    p_matches_ref_r1: assert (prod == {16'd0, op_a} * {16'd0, op_b});
    p_zero_r3: assert ((op_a != 0 && op_b != 0) || prod == 0);
    p_unit_r4: assert (op_a != 16'd1 || prod == {16'd0, op_b});
    p_lsb_r5:  assert (prod[0] == (op_a[0] & op_b[0]));
  end
endmodule

// File: tb/sim_qmul16.sv
module sim_qmul16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;

  qmul16 u0 (.op_a(a16), .op_b(b16), .prod(p16));
  qmul8  u8 (.a(a8), .b(b8), .p(p8));
  qmul4  u4 (.a(a4), .b(b4), .p(p4));
  qmul2  u2 (.a(a2), .b(b2), .p(p2));

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // {op_a, op_b, expected product}
  localparam logic [63:0] VEC [11] = '{
    {16'h0000, 16'h0000, 32'h00000000},
    {16'h0000, 16'hFFFF, 32'h00000000},
    {16'hFFFF, 16'h0001, 32'h0000FFFF},
    {16'h0001, 16'h1234, 32'h00001234},
    {16'hFFFF, 16'hFFFF, 32'hFFFE0001},
    {16'h00FF, 16'h00FF, 32'h0000FE01},
    {16'h0100, 16'h0100, 32'h00010000},
    {16'h8000, 16'h0002, 32'h00010000},
    {16'h1234, 16'h0010, 32'h00012340},
    {16'h8000, 16'h8000, 32'h40000000},
    {16'h00FF, 16'hFF00, 32'h00FE0100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a16 = 0; b16 = 0; a8 = 0; b8 = 0; a4 = 0; b4 = 0; a2 = 0; b2 = 0;
    @(negedge clk);
    check("R3 idle zero operands top", p16, 32'd0);
    check("R3 idle zero operands 8x8", {16'd0, p8}, 32'd0);

    for (int i = 0; i < 11; i++) begin
      @(posedge clk);
      a16 = VEC[i][63:48];
      b16 = VEC[i][47:32];
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), p16, VEC[i][31:0]);
    end

    @(posedge clk); a16 = 16'hFFFF; b16 = 16'hFFFF;
    @(negedge clk); check("R6 all-ones squared", p16, 32'hFFFE0001);
    @(posedge clk); a16 = 16'h0000; b16 = 16'hBEEF;
    @(negedge clk); check("R3 zero times nonzero", p16, 32'd0);
    @(posedge clk); a16 = 16'hCAFE; b16 = 16'h0001;
    @(negedge clk); check("R4 unit right operand", p16, 32'h0000CAFE);
    @(posedge clk); a16 = 16'h0003; b16 = 16'h0005;
    @(negedge clk); check("R5 odd times odd lsb", {31'd0, p16[0]}, 32'd1);

    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        @(posedge clk); a2 = 2'(x); b2 = 2'(y);
        @(negedge clk); check($sformatf("R2 cell %0dx%0d", x, y), {28'd0, p2}, 32'(x * y));
      end
    end

    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(posedge clk); a4 = 4'(x); b4 = 4'(y);
        @(negedge clk); check($sformatf("R7 4x4 %0dx%0d", x, y), {24'd0, p4}, 32'(x * y));
      end
    end

    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom); rb = 8'($urandom);
      @(posedge clk); a8 = ra; b8 = rb;
      @(negedge clk); check("R7 8x8 random", {16'd0, p8}, {16'd0, ra} * {16'd0, rb});
    end
    @(posedge clk); a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk); check("R7 8x8 all ones", {16'd0, p8}, 32'h0000FE01);

    for (int i = 0; i < 2000; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom); rb = 16'($urandom);
      @(posedge clk); a16 = ra; b16 = rb;
      @(negedge clk); check("R1 R8 16x16 random", p16, {16'd0, ra} * {16'd0, rb});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule